// File: doc/BRIEF.md
# Host-to-PCI Bridge Window Register Bank

This block is the memory-mapped register store for the address windows of a host-to-PCI bridge. It sits inside a 4 KB control space and is reached through a plain word-wide register port (address, write strobe, read strobe, write data and registered read data). It holds four outbound window sets, which map host addresses onto the PCI bus, and three inbound window sets, which map PCI addresses onto host memory. It also holds one general-purpose gasket timer word.

The translation logic next to this bank does not read registers over the port. It takes every window's fields straight from the exported buses. Each window also drives a one-cycle update strobe whenever one of its registers is written, so that the translation logic knows when to rebuild that window's mapping. Every register clears on reset, which leaves every window disabled.

The port carries whole 32-bit words. When the host bus is big-endian, its byte order is applied outside this block. The configuration address word at offset 0x0 and the configuration data word at offset 0x4 belong to a neighbouring block. Here they read as zero.

Top module: `pcib_winbank`

## Requirements
- R1: While reset is high and in the cycle after it, all exported window fields, both strobe vectors and the read data are zero.
- R2: Outbound window w (0..3) answers at address 0xC20 + 0x20*w. Within the window, offset 0x00 holds the translation address, 0x04 the extended translation address, 0x08 the window base and 0x10 the attributes. A written value appears on that window's exported field in the cycle after the write, and it reads back unchanged.
- R3: Inbound window j (0..2) answers at address 0xDA0 + 0x20*j, so 0xDE0 is window 2. Within the window, offset 0x00 holds the translation address, 0x08 the window base, 0x0C the extended base and 0x10 the attributes. A written value is exported and reads back as in R2.
- R4: The word at 0xE20 is a plain storage register that reads back what was last written to it.
- R5: A read of any address that decodes to no register returns zero. This includes 0x000, 0x004, 0xC00, 0xCA0, 0xD80 and 0xE24, offset 0x0C of an outbound window, offset 0x04 of an inbound window, and offset 0x14 of any window.
- R6: A write to an undecoded address changes no exported field and no stored register, and it raises no update strobe.
- R7: A write to any decoded register of a window raises only that window's update strobe, in the cycle after the write and for exactly one cycle.
- R8: Read data is registered. It takes the addressed value in the cycle after the read strobe and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 12 | Byte address within the control space |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| out_xlat | output | 128 | Outbound translation addresses, window w in bits [32w+31:32w] |
| out_xlat_ext | output | 128 | Outbound extended translation addresses |
| out_base | output | 128 | Outbound window bases |
| out_attr | output | 128 | Outbound window attributes |
| out_upd | output | 4 | Outbound per-window update strobes |
| in_xlat | output | 96 | Inbound translation addresses, window j in bits [32j+31:32j] |
| in_base | output | 96 | Inbound window bases |
| in_base_ext | output | 96 | Inbound extended window bases |
| in_attr | output | 96 | Inbound window attributes |
| in_upd | output | 3 | Inbound per-window update strobes |

## Verification
The bench builds the bank with its default parameters: four outbound windows based at 0xC20, three inbound windows based at 0xDA0, and the timer at 0xE20. With these values, every real register in the map is addressed. So are the near misses on either side of the window groups: the group slot just below the first outbound window, the slot just after the last one, the slot below the first inbound window, and the word after the timer. Writing every register with a value unique to its window and field shows that a mis-routed lane or a swapped inbound index ends up on the wrong export.

// File: rtl/pcib_pkg.sv
package pcib_pkg;

  parameter int unsigned PCIB_DW = 32;
  parameter int unsigned PCIB_OW = 5;

  localparam logic [PCIB_OW-1:0] OFF_XLAT    = 5'h00;
  localparam logic [PCIB_OW-1:0] OFF_OUT_EXT = 5'h04;
  localparam logic [PCIB_OW-1:0] OFF_BASE    = 5'h08;
  localparam logic [PCIB_OW-1:0] OFF_IN_EXT  = 5'h0C;
  localparam logic [PCIB_OW-1:0] OFF_ATTR    = 5'h10;

  typedef struct packed {
    logic [PCIB_DW-1:0] xlat;
    logic [PCIB_DW-1:0] ext;
    logic [PCIB_DW-1:0] base;
    logic [PCIB_DW-1:0] attr;
  } pcib_win_t;

endpackage

// File: rtl/pcib_decode.sv
module pcib_decode
  import pcib_pkg::*;
#(
  parameter int          AW       = 12,
  parameter int          N_OUT    = 4,
  parameter int          N_IN     = 3,
  parameter logic [AW-1:0] OUT_BASE = 12'hC20,
  parameter logic [AW-1:0] IN_BASE  = 12'hDA0,
  parameter logic [AW-1:0] TMR_ADDR = 12'hE20
) (
  input  logic [AW-1:0]      addr,
  output logic [N_OUT-1:0]   out_sel,
  output logic [N_IN-1:0]    in_sel,
  output logic               tmr_sel,
  output logic [PCIB_OW-1:0] off
);

  localparam int GW = AW - PCIB_OW;
  localparam logic [GW-1:0] OUT_GRP = OUT_BASE[AW-1:PCIB_OW];
  localparam logic [GW-1:0] IN_GRP  = IN_BASE[AW-1:PCIB_OW];

  logic [GW-1:0] grp;
  assign grp = addr[AW-1:PCIB_OW];
  assign off = addr[PCIB_OW-1:0];

  for (genvar w = 0; w < N_OUT; w++) begin : g_osel
    assign out_sel[w] = (grp == OUT_GRP + GW'(w));
  end

  for (genvar j = 0; j < N_IN; j++) begin : g_isel
    assign in_sel[j] = (grp == IN_GRP + GW'(j));
  end

  assign tmr_sel = (addr == TMR_ADDR);

endmodule

// File: rtl/pcib_winset.sv
module pcib_winset
  import pcib_pkg::*;
#(
  parameter bit INBOUND = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               wr,
  input  logic [PCIB_OW-1:0] off,
  input  logic [PCIB_DW-1:0] wdata,
  output pcib_win_t          fields,
  output logic               upd,
  output logic [PCIB_DW-1:0] rd_val
);

  localparam logic [PCIB_OW-1:0] EXT_OFF = INBOUND ? OFF_IN_EXT : OFF_OUT_EXT;

  logic hit_xlat, hit_ext, hit_base, hit_attr, hit_any;

  always_comb begin
    hit_xlat = sel && (off == OFF_XLAT);
    hit_ext  = sel && (off == EXT_OFF);
    hit_base = sel && (off == OFF_BASE);
    hit_attr = sel && (off == OFF_ATTR);
    hit_any  = hit_xlat | hit_ext | hit_base | hit_attr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fields <= '0;
      upd    <= 1'b0;
    end else begin
      upd <= wr && hit_any;
      if (wr && hit_xlat) fields.xlat <= wdata;
      if (wr && hit_ext)  fields.ext  <= wdata;
      if (wr && hit_base) fields.base <= wdata;
      if (wr && hit_attr) fields.attr <= wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit_xlat) rd_val = fields.xlat;
    if (hit_ext)  rd_val = fields.ext;
    if (hit_base) rd_val = fields.base;
    if (hit_attr) rd_val = fields.attr;
  end

endmodule

// File: rtl/pcib_rdmux.sv
module pcib_rdmux
  import pcib_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd,
  input  logic [N*PCIB_DW-1:0] cand,
  output logic [PCIB_DW-1:0]   rdata
);

  logic [PCIB_DW-1:0] merged;

  always_comb begin
    merged = '0;
    for (int i = 0; i < N; i++) begin
      merged = merged | cand[i*PCIB_DW +: PCIB_DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= merged;
    end
  end

endmodule

// File: rtl/pcib_winbank.sv
module pcib_winbank
  import pcib_pkg::*;
#(
  parameter int            AW       = 12,
  parameter int            N_OUT    = 4,
  parameter int            N_IN     = 3,
  parameter logic [AW-1:0] OUT_BASE = 12'hC20,
  parameter logic [AW-1:0] IN_BASE  = 12'hDA0,
  parameter logic [AW-1:0] TMR_ADDR = 12'hE20,
  parameter int            DW       = PCIB_DW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       reg_addr,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  output logic [N_OUT*DW-1:0] out_xlat,
  output logic [N_OUT*DW-1:0] out_xlat_ext,
  output logic [N_OUT*DW-1:0] out_base,
  output logic [N_OUT*DW-1:0] out_attr,
  output logic [N_OUT-1:0]    out_upd,
  output logic [N_IN*DW-1:0]  in_xlat,
  output logic [N_IN*DW-1:0]  in_base,
  output logic [N_IN*DW-1:0]  in_base_ext,
  output logic [N_IN*DW-1:0]  in_attr,
  output logic [N_IN-1:0]     in_upd
);

  localparam int N_SRC = N_OUT + N_IN + 1;

  logic [N_OUT-1:0]     out_sel;
  logic [N_IN-1:0]      in_sel;
  logic                 tmr_sel;
  logic [PCIB_OW-1:0]   off;
  logic [DW-1:0]        tmr_q;
  logic [N_SRC*DW-1:0]  cand;

  pcib_decode #(
    .AW(AW), .N_OUT(N_OUT), .N_IN(N_IN),
    .OUT_BASE(OUT_BASE), .IN_BASE(IN_BASE), .TMR_ADDR(TMR_ADDR)
  ) u_dec (
    .addr(reg_addr), .out_sel(out_sel), .in_sel(in_sel),
    .tmr_sel(tmr_sel), .off(off)
  );

  for (genvar w = 0; w < N_OUT; w++) begin : g_out
    pcib_win_t f;
    pcib_winset #(.INBOUND(1'b0)) u_set (
      .clk(clk), .rst(rst), .sel(out_sel[w]), .wr(reg_wr), .off(off),
      .wdata(reg_wdata), .fields(f), .upd(out_upd[w]),
      .rd_val(cand[w*DW +: DW])
    );
    assign out_xlat[w*DW +: DW]     = f.xlat;
    assign out_xlat_ext[w*DW +: DW] = f.ext;
    assign out_base[w*DW +: DW]     = f.base;
    assign out_attr[w*DW +: DW]     = f.attr;
  end

  for (genvar j = 0; j < N_IN; j++) begin : g_in
    pcib_win_t f;
    pcib_winset #(.INBOUND(1'b1)) u_set (
      .clk(clk), .rst(rst), .sel(in_sel[j]), .wr(reg_wr), .off(off),
      .wdata(reg_wdata), .fields(f), .upd(in_upd[j]),
      .rd_val(cand[(N_OUT+j)*DW +: DW])
    );
    assign in_xlat[j*DW +: DW]     = f.xlat;
    assign in_base_ext[j*DW +: DW] = f.ext;
    assign in_base[j*DW +: DW]     = f.base;
    assign in_attr[j*DW +: DW]     = f.attr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q <= '0;
    end else if (reg_wr && tmr_sel) begin
      tmr_q <= reg_wdata;
    end
  end

  assign cand[(N_SRC-1)*DW +: DW] = tmr_sel ? tmr_q : '0;

  pcib_rdmux #(.N(N_SRC)) u_rd (
    .clk(clk), .rst(rst), .rd(reg_rd), .cand(cand), .rdata(reg_rdata)
  );

endmodule

// File: rtl/pcib_winbank_chk.sv
module pcib_winbank_chk #(
  parameter int            AW       = 12,
  parameter int            N_OUT    = 4,
  parameter int            N_IN     = 3,
  parameter logic [AW-1:0] OUT_BASE = 12'hC20,
  parameter logic [AW-1:0] IN_BASE  = 12'hDA0,
  parameter int            DW       = 32
) (
  input logic                clk,
  input logic                rst,
  input logic [AW-1:0]       reg_addr,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [DW-1:0]       reg_rdata,
  input logic [N_OUT*DW-1:0] out_xlat,
  input logic [N_OUT*DW-1:0] out_xlat_ext,
  input logic [N_OUT*DW-1:0] out_base,
  input logic [N_OUT*DW-1:0] out_attr,
  input logic [N_OUT-1:0]    out_upd,
  input logic [N_IN*DW-1:0]  in_xlat,
  input logic [N_IN*DW-1:0]  in_base,
  input logic [N_IN*DW-1:0]  in_base_ext,
  input logic [N_IN*DW-1:0]  in_attr,
  input logic [N_IN-1:0]     in_upd
);

  localparam logic [AW-1:0] IN_LAST = IN_BASE + AW'((N_IN-1)*32);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (reg_rdata == '0 && out_upd == '0 && in_upd == '0 &&
             out_attr == '0 && in_attr == '0));

  // R7
  upd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_upd, in_upd}));

  // R7
  upd_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ((out_upd != '0) || (in_upd != '0)) |-> $past(reg_wr));

  // R2
  out_first_upd_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == OUT_BASE) |=> out_upd[0]);

  // R3
  in_last_upd_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == IN_LAST) |=> in_upd[N_IN-1]);

  // R6
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> ($stable(out_xlat) && $stable(out_xlat_ext) &&
                 $stable(out_base) && $stable(out_attr) &&
                 $stable(in_xlat) && $stable(in_base) &&
                 $stable(in_base_ext) && $stable(in_attr)));

  // R5
  low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr < OUT_BASE) |=> reg_rdata == '0);

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));

endmodule

bind pcib_winbank pcib_winbank_chk #(
  .AW(AW), .N_OUT(N_OUT), .N_IN(N_IN),
  .OUT_BASE(OUT_BASE), .IN_BASE(IN_BASE), .DW(DW)
) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .out_xlat(out_xlat), .out_xlat_ext(out_xlat_ext), .out_base(out_base),
  .out_attr(out_attr), .out_upd(out_upd),
  .in_xlat(in_xlat), .in_base(in_base), .in_base_ext(in_base_ext),
  .in_attr(in_attr), .in_upd(in_upd)
);

// File: tb/pcib_winbank_bench.sv
module pcib_winbank_bench;

  localparam int NO = 4;
  localparam int NI = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NO*32-1:0] out_xlat, out_xlat_ext, out_base, out_attr;
  logic [NO-1:0] out_upd;
  logic [NI*32-1:0] in_xlat, in_base, in_base_ext, in_attr;
  logic [NI-1:0] in_upd;

  int total = 0;
  int bad = 0;
  logic [NO+NI-1:0] upd_seen;

  always #10 clk = ~clk;

  pcib_winbank u_pcib_winbank (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .out_xlat(out_xlat), .out_xlat_ext(out_xlat_ext), .out_base(out_base),
    .out_attr(out_attr), .out_upd(out_upd),
    .in_xlat(in_xlat), .in_base(in_base), .in_base_ext(in_base_ext),
    .in_attr(in_attr), .in_upd(in_upd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    upd_seen = {in_upd, out_upd};
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] pat(input int grp, input int w, input int r);
    return 32'hA500_0000 | (grp << 16) | (w << 8) | r;
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 rdata", reg_rdata, 32'h0);
    chk("R1 out_upd", {28'h0, out_upd}, 32'h0);
    chk("R1 in_upd", {29'h0, in_upd}, 32'h0);
    chk("R1 out_attr w3", out_attr[3*32 +: 32], 32'h0);
    chk("R1 in_xlat w0", in_xlat[31:0], 32'h0);
    rd(12'hC28, v); chk("R1 read out base", v, 32'h0);
    rd(12'hDF0, v); chk("R1 read in attr", v, 32'h0);
    rd(12'hE20, v); chk("R1 read timer", v, 32'h0);
  endtask

  task automatic t_outbound;
    logic [31:0] v;
    logic [11:0] offs [4] = '{12'h00, 12'h04, 12'h08, 12'h10};
    for (int w = 0; w < NO; w++) begin
      for (int r = 0; r < 4; r++) begin
        wr(12'hC20 + 12'(w*32) + offs[r], pat(1, w, r));
        chk("R7 outbound strobe", {25'h0, upd_seen}, 32'(1 << w));
        @(negedge clk);
        chk("R7 outbound strobe width", {28'h0, out_upd}, 32'h0);
      end
    end
    for (int w = 0; w < NO; w++) begin
      chk("R2 out_xlat", out_xlat[w*32 +: 32], pat(1, w, 0));
      chk("R2 out_xlat_ext", out_xlat_ext[w*32 +: 32], pat(1, w, 1));
      chk("R2 out_base", out_base[w*32 +: 32], pat(1, w, 2));
      chk("R2 out_attr", out_attr[w*32 +: 32], pat(1, w, 3));
      for (int r = 0; r < 4; r++) begin
        rd(12'hC20 + 12'(w*32) + offs[r], v);
        chk("R2 outbound readback", v, pat(1, w, r));
      end
    end
  endtask

  task automatic t_inbound;
    logic [31:0] v;
    logic [11:0] offs [4] = '{12'h00, 12'h08, 12'h0C, 12'h10};
    for (int j = 0; j < NI; j++) begin
      for (int r = 0; r < 4; r++) begin
        wr(12'hDA0 + 12'(j*32) + offs[r], pat(2, j, r));
        chk("R7 inbound strobe", {25'h0, upd_seen}, 32'(1 << (NO + j)));
      end
    end
    for (int j = 0; j < NI; j++) begin
      chk("R3 in_xlat", in_xlat[j*32 +: 32], pat(2, j, 0));
      chk("R3 in_base", in_base[j*32 +: 32], pat(2, j, 1));
      chk("R3 in_base_ext", in_base_ext[j*32 +: 32], pat(2, j, 2));
      chk("R3 in_attr", in_attr[j*32 +: 32], pat(2, j, 3));
      for (int r = 0; r < 4; r++) begin
        rd(12'hDA0 + 12'(j*32) + offs[r], v);
        chk("R3 inbound readback", v, pat(2, j, r));
      end
    end
    rd(12'hDE8, v); chk("R3 0xDE0 is window 2", v, pat(2, 2, 1));
  endtask

  task automatic t_timer;
    logic [31:0] v;
    wr(12'hE20, 32'h1357_9BDF);
    chk("R4 timer no strobe", {25'h0, upd_seen}, 32'h0);
    rd(12'hE20, v); chk("R4 timer readback", v, 32'h1357_9BDF);
    wr(12'hE20, 32'hFFFF_0001);
    rd(12'hE20, v); chk("R4 timer rewrite", v, 32'hFFFF_0001);
  endtask

  task automatic t_undec_read;
    logic [31:0] v;
    logic [11:0] list [10] = '{12'h000, 12'h004, 12'hC00, 12'hCA0, 12'hD80,
                               12'hE24, 12'hC2C, 12'hDA4, 12'hC34, 12'hDB4};
    for (int i = 0; i < 10; i++) begin
      rd(list[i], v);
      chk($sformatf("R5 undecoded read %h", list[i]), v, 32'h0);
    end
  endtask

  task automatic t_undec_write;
    logic [31:0] v;
    logic [NO*32-1:0] sx, se, sb, sa;
    logic [NI*32-1:0] ix, ib, ie, ia;
    logic [11:0] list [8] = '{12'h000, 12'h004, 12'hC00, 12'hCA0,
                              12'hD80, 12'hE24, 12'hC2C, 12'hDA4};
    sx = out_xlat; se = out_xlat_ext; sb = out_base; sa = out_attr;
    ix = in_xlat; ib = in_base; ie = in_base_ext; ia = in_attr;
    for (int i = 0; i < 8; i++) begin
      wr(list[i], 32'hFFFF_FFFF);
      chk($sformatf("R6 no strobe %h", list[i]), {25'h0, upd_seen}, 32'h0);
    end
    chk("R6 out exports unchanged", 32'((out_xlat != sx) || (out_xlat_ext != se) ||
        (out_base != sb) || (out_attr != sa)), 32'h0);
    chk("R6 in exports unchanged", 32'((in_xlat != ix) || (in_base != ib) ||
        (in_base_ext != ie) || (in_attr != ia)), 32'h0);
    rd(12'hE20, v); chk("R6 timer unchanged", v, 32'hFFFF_0001);
    rd(12'hC2C, v); chk("R6 hole still zero", v, 32'h0);
  endtask

  task automatic t_latency;
    logic [31:0] v;
    rd(12'hC40, v); chk("R8 first read", v, pat(1, 1, 0));
    @(negedge clk);
    reg_addr = 12'hDC0; reg_rd = 1'b0;
    @(negedge clk);
    chk("R8 hold without strobe", reg_rdata, pat(1, 1, 0));
    reg_rd = 1'b1;
    #2;
    chk("R8 old value before edge", reg_rdata, pat(1, 1, 0));
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R8 new value after edge", reg_rdata, pat(2, 1, 0));
    @(negedge clk);
    chk("R8 hold after read", reg_rdata, pat(2, 1, 0));
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_outbound();
    t_inbound();
    t_timer();
    t_undec_read();
    t_undec_write();
    t_latency();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule